// File: doc/BRIEF.md
# Active-Panel Pixel Formatter

This block sits between a frame-buffer word FIFO and the data pins of an active-matrix panel. It takes 32-bit words that hold packed pixels, splits each word into pixels starting at the least significant end, and sends out one 16-bit colour per handshake. At 4 and 8 bits per pixel, every unpacked value is an index into an on-block palette of 16-bit colours, and the palette entry goes out unaltered. At 16 bits per pixel, each word carries two colours that go out as they are. No dithering is applied on either path.

Next to the 16-bit colour, the block drives a 24-bit 8:8:8 copy for panels with more than 16 data lines. A split setting tells it how the 16 bits divide among red, green and blue. A widening setting places each colour on the high or low end of its 8-bit lane and fills the rest with a chosen constant, or repeats the colour's top bits in the lane's low bits. Bit depths that an active panel cannot use raise an error flag. Input words that arrive in such a depth are taken from the FIFO and thrown away.

Top module: `tft_pixel_fmt`

## Requirements
- R1: `cfg_bpp` codes are 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp, and 5 to 7 are unused. While `cfg_active` is high and the code is not 2, 3 or 4, `mode_err` is high and `in_ready` is high. Every word accepted in that state is discarded, and no pixel comes out for it.
- R2: While `cfg_active` is low, `in_ready` is low and no word is accepted.
- R3: At 4 bpp, a word yields 8 pixels. Pixel k is bits [4k+3:4k], used as a palette index (entries 0 to 15), and the output is that palette entry.
- R4: At 8 bpp, a word yields 4 pixels. Pixel k is bits [8k+7:8k], used as a palette index, and the output is that palette entry.
- R5: At 16 bpp, a word yields 2 pixels: first bits [15:0], then bits [31:16]. Both are output unchanged, with no palette lookup.
- R6: A palette write (`pal_we` high at a clock edge) stores `pal_wdata` at `pal_waddr`. Every pixel issued after that edge sees the new entry.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` stays unchanged. Pixels leave in input order.
- R8: `in_ready` is low while a word accepted in a valid depth still has pixels that have not been issued.
- R9: `cfg_split` selects the 16-bit colour split: 0=6:5:5, 1=5:6:5, 2=5:5:6 (red:green:blue from the top bit down), and 3 behaves like 1. `out_wide` is {red[7:0], green[7:0], blue[7:0]}.
- R10: With `cfg_widen`=0, each colour sits in the top bits of its 8-bit lane, and the remaining low bits all equal `cfg_fill`.
- R11: With `cfg_widen`=1, each colour sits in the low bits of its lane, and the remaining high bits all equal `cfg_fill`.
- R12: With `cfg_widen`=2 or 3, each colour sits in the top bits of its lane, and its own top bits are repeated into the remaining low bits.
- R13: After reset, `out_valid` is low and no word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_active | input | 1 | Enables active-panel operation |
| cfg_bpp | input | 3 | Bits-per-pixel code (R1) |
| cfg_split | input | 2 | Colour split select (R9) |
| cfg_widen | input | 2 | Widening mode (R10 to R12) |
| cfg_fill | input | 1 | Constant fill bit for widening |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 8 | Palette write address |
| pal_wdata | input | 16 | Palette write data |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Frame-buffer word |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts pixel |
| out_pix | output | 16 | 16-bit colour |
| out_wide | output | 24 | 8:8:8 widened colour |
| mode_err | output | 1 | Unsupported depth in active operation |

## Verification
The assertions check on every cycle that a stalled pixel holds still, that the input stays blocked while a word is held, that the error flag and the idle state gate the input, and how the 5:6:5 split widens in the top-placement and repeat modes. Only the bench's scenarios can show that unpacking starts at the low end and runs in the right order at each depth, that palette contents and rewrites reach the output, that a discarded word never shows up later, and that the 6:5:5 and 5:5:6 splits widen correctly with both fill values.

// File: rtl/tft_fmt_pkg.sv
package tft_fmt_pkg;

   typedef enum logic [2:0] {
      BPP_1  = 3'd0,
      BPP_2  = 3'd1,
      BPP_4  = 3'd2,
      BPP_8  = 3'd3,
      BPP_16 = 3'd4
   } bpp_e;

   typedef enum logic [1:0] {
      WID_TOP  = 2'd0,
      WID_LOW  = 2'd1,
      WID_COPY = 2'd2
   } widen_e;

   // v is a colour field left-justified in 6 bits; six selects 6-bit width
   function automatic logic [7:0] widen_chan(input logic [5:0] v,
                                             input logic       six,
                                             input logic [1:0] mode,
                                             input logic       fill);
      logic [4:0] c5;
      c5 = v[5:1];
      if (six) begin
         case (mode)
            WID_TOP: widen_chan = {v, {2{fill}}};
            WID_LOW: widen_chan = {{2{fill}}, v};
            default: widen_chan = {v, v[5:4]};
         endcase
      end else begin
         case (mode)
            WID_TOP: widen_chan = {c5, {3{fill}}};
            WID_LOW: widen_chan = {{3{fill}}, c5};
            default: widen_chan = {c5, c5[4:2]};
         endcase
      end
   endfunction

endpackage

// File: rtl/tft_unpack.sv
module tft_unpack
   import tft_fmt_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 3
) (
   input  logic [WORD_W-1:0] word,
   input  logic [CNT_W-1:0]  cnt,
   input  bpp_e              bpp,
   output logic [15:0]       val,
   output logic              last
);

   localparam int N4  = WORD_W / 4;
   localparam int N8  = WORD_W / 8;
   localparam int N16 = WORD_W / 16;

   logic [3:0]  lane4  [N4];
   logic [7:0]  lane8  [N8];
   logic [15:0] lane16 [N16];

   for (genvar i = 0; i < N4; i++) begin : g_l4
      assign lane4[i] = word[4*i +: 4];
   end
   for (genvar i = 0; i < N8; i++) begin : g_l8
      assign lane8[i] = word[8*i +: 8];
   end
   for (genvar i = 0; i < N16; i++) begin : g_l16
      assign lane16[i] = word[16*i +: 16];
   end

   always_comb begin
      case (bpp)
         BPP_4: begin
            val  = {12'd0, lane4[cnt]};
            last = (cnt == CNT_W'(N4 - 1));
         end
         BPP_8: begin
            val  = {8'd0, lane8[cnt[CNT_W-2:0]]};
            last = (cnt[CNT_W-2:0] == (CNT_W-1)'(N8 - 1));
         end
         default: begin
            val  = lane16[cnt[CNT_W-3:0]];
            last = (cnt[CNT_W-3:0] == (CNT_W-2)'(N16 - 1));
         end
      endcase
   end

endmodule

// File: rtl/tft_palette.sv
module tft_palette #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [15:0]   wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [15:0]   rdata
);

   logic [15:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[raddr];
   end

endmodule

// File: rtl/tft_widen.sv
module tft_widen
   import tft_fmt_pkg::*;
(
   input  logic [15:0] pix,
   input  logic [1:0]  split,
   input  logic [1:0]  mode,
   input  logic        fill,
   output logic [23:0] wide
);

   logic [5:0] fld [3];
   logic [2:0] six;

   always_comb begin
      case (split)
         2'd0: begin
            fld[0] = pix[15:10];
            fld[1] = {pix[9:5], 1'b0};
            fld[2] = {pix[4:0], 1'b0};
            six    = 3'b001;
         end
         2'd2: begin
            fld[0] = {pix[15:11], 1'b0};
            fld[1] = {pix[10:6], 1'b0};
            fld[2] = pix[5:0];
            six    = 3'b100;
         end
         default: begin
            fld[0] = {pix[15:11], 1'b0};
            fld[1] = pix[10:5];
            fld[2] = {pix[4:0], 1'b0};
            six    = 3'b010;
         end
      endcase
   end

   for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      assign wide[23-8*ch -: 8] = widen_chan(fld[ch], six[ch], mode, fill);
   end

endmodule

// File: rtl/tft_pixel_fmt.sv
module tft_pixel_fmt
   import tft_fmt_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int PAL_DEPTH = 256,
   parameter int WIDE_W    = 24
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_active,
   input  logic [2:0]                   cfg_bpp,
   input  logic [1:0]                   cfg_split,
   input  logic [1:0]                   cfg_widen,
   input  logic                         cfg_fill,
   input  logic                         pal_we,
   input  logic [$clog2(PAL_DEPTH)-1:0] pal_waddr,
   input  logic [15:0]                  pal_wdata,
   input  logic                         in_valid,
   input  logic [WORD_W-1:0]            in_data,
   output logic                         in_ready,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [15:0]                  out_pix,
   output logic [WIDE_W-1:0]            out_wide,
   output logic                         mode_err
);

   localparam int CNT_W = $clog2(WORD_W / 4);
   localparam int AW    = $clog2(PAL_DEPTH);

   if (WORD_W < 32 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 32");
   end
   if (PAL_DEPTH < 256 || AW > 16) begin : g_bad_pal
      $error("PAL_DEPTH must hold every 8-bit index");
   end
   if (WIDE_W != 24) begin : g_bad_wide
      $error("WIDE_W must be 24 (8:8:8)");
   end

   bpp_e bpp;
   logic mode_ok;
   assign bpp      = bpp_e'(cfg_bpp);
   assign mode_ok  = (bpp == BPP_4) || (bpp == BPP_8) || (bpp == BPP_16);
   assign mode_err = cfg_active && !mode_ok;

   // unpack stage
   logic              a_valid;
   logic [WORD_W-1:0] a_word;
   logic [CNT_W-1:0]  a_cnt;
   logic [15:0]       val;
   logic              last;
   logic              issue, accept;

   // output stage
   logic        b_valid, b_direct;
   logic [15:0] b_raw, pal_rdata;

   assign in_ready = cfg_active && (mode_err || !a_valid);
   assign accept   = in_valid && in_ready;
   assign issue    = a_valid && mode_ok && (!b_valid || out_ready);

   tft_unpack #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_unpack (
      .word (a_word),
      .cnt  (a_cnt),
      .bpp  (bpp),
      .val  (val),
      .last (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid <= 1'b0;
         a_word  <= '0;
         a_cnt   <= '0;
      end else if (accept && !mode_err) begin
         a_valid <= 1'b1;
         a_word  <= in_data;
         a_cnt   <= '0;
      end else if (issue) begin
         if (last) a_valid <= 1'b0;
         a_cnt <= a_cnt + 1'b1;
      end
   end

   tft_palette #(.DEPTH(PAL_DEPTH), .AW(AW)) i_pal (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (pal_we),
      .waddr (pal_waddr),
      .wdata (pal_wdata),
      .re    (issue && (bpp != BPP_16)),
      .raddr (val[AW-1:0]),
      .rdata (pal_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_valid  <= 1'b0;
         b_direct <= 1'b0;
         b_raw    <= '0;
      end else if (issue) begin
         b_valid  <= 1'b1;
         b_direct <= (bpp == BPP_16);
         b_raw    <= val;
      end else if (out_ready) begin
         b_valid  <= 1'b0;
      end
   end

   assign out_valid = b_valid;
   assign out_pix   = b_direct ? b_raw : pal_rdata;

   tft_widen i_widen (
      .pix   (out_pix),
      .split (cfg_split),
      .mode  (cfg_widen),
      .fill  (cfg_fill),
      .wide  (out_wide)
   );

endmodule

// File: rtl/tft_pixel_fmt_chk.sv
module tft_pixel_fmt_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_active,
   input logic [2:0]  cfg_bpp,
   input logic [1:0]  cfg_split,
   input logic [1:0]  cfg_widen,
   input logic        cfg_fill,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [15:0] out_pix,
   input logic [23:0] out_wide,
   input logic        mode_err
);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !mode_err) |=> !in_ready);

   assert_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active && (cfg_bpp == 3'd0 || cfg_bpp == 3'd1)) |-> (mode_err && in_ready));

   assert_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_err && !out_valid) |=> !out_valid);

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_active |-> !in_ready);

   assert_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_widen == 2'd0 && cfg_split == 2'd1) |->
      (out_wide[23:19] == out_pix[15:11] && out_wide[18:16] == {3{cfg_fill}}));

   assert_copy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_widen == 2'd2 && cfg_split == 2'd1) |->
      (out_wide[7:3] == out_pix[4:0] && out_wide[2:0] == out_pix[4:2]));

endmodule

bind tft_pixel_fmt tft_pixel_fmt_chk i_chk (.*);

// File: tb/test_tft_pixel_fmt.sv
module test_tft_pixel_fmt;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_active = 1'b1;
   logic [2:0]  cfg_bpp = 3'd4;
   logic [1:0]  cfg_split = 2'd1;
   logic [1:0]  cfg_widen = 2'd0;
   logic        cfg_fill = 1'b0;
   logic        pal_we = 1'b0;
   logic [7:0]  pal_waddr = '0;
   logic [15:0] pal_wdata = '0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [15:0] out_pix;
   logic [23:0] out_wide;
   logic        mode_err;

   always #5 clk = ~clk;

   tft_pixel_fmt i_tft_pixel_fmt (.*);

   int          errors = 0;
   int          checks = 0;
   int          cyc = 0;
   bit          stall_en = 1'b0;
   logic [15:0] pm [256];
   logic [15:0] q_pix [$];
   logic [23:0] q_wide [$];
   string       q_ptag [$];
   string       q_wtag [$];

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] lane(input logic [5:0] v, input int w, input logic [1:0] mode, input logic fill);
      logic [7:0] fm;
      logic [7:0] sh;
      fm = (8'hFF >> w);
      sh = 8'(v) << (8 - w);
      if (mode == 2'd0)      return sh | (fill ? fm : 8'h00);
      else if (mode == 2'd1) return 8'(v) | (fill ? ~(8'hFF >> (8 - w)) : 8'h00);
      else                   return sh | 8'(v >> (2 * w - 8));
   endfunction

   function automatic logic [23:0] exp_wide(input logic [15:0] p);
      logic [5:0] r, g, b;
      int wr, wg, wb;
      if (cfg_split == 2'd0) begin
         r = p[15:10]; g = 6'(p[9:5]); b = 6'(p[4:0]); wr = 6; wg = 5; wb = 5;
      end else if (cfg_split == 2'd2) begin
         r = 6'(p[15:11]); g = 6'(p[10:6]); b = p[5:0]; wr = 5; wg = 5; wb = 6;
      end else begin
         r = 6'(p[15:11]); g = p[10:5]; b = 6'(p[4:0]); wr = 5; wg = 6; wb = 5;
      end
      return {lane(r, wr, cfg_widen, cfg_fill), lane(g, wg, cfg_widen, cfg_fill),
              lane(b, wb, cfg_widen, cfg_fill)};
   endfunction

   function automatic string wtag();
      if (cfg_widen == 2'd0) return "R9/R10";
      if (cfg_widen == 2'd1) return "R9/R11";
      return "R9/R12";
   endfunction

   task automatic push_pix(input logic [15:0] p, input string tag);
      q_pix.push_back(p);
      q_wide.push_back(exp_wide(p));
      q_ptag.push_back(tag);
      q_wtag.push_back(wtag());
   endtask

   // expected pixels per word: low end first
   task automatic push_word(input logic [31:0] w, input string tag);
      if (cfg_bpp == 3'd2) begin
         for (int k = 0; k < 8; k++) push_pix(pm[8'(w[4*k +: 4])], tag);
      end else if (cfg_bpp == 3'd3) begin
         for (int k = 0; k < 4; k++) push_pix(pm[w[8*k +: 8]], tag);
      end else begin
         push_pix(w[15:0], tag);
         push_pix(w[31:16], tag);
      end
   endtask

   task automatic send(input logic [31:0] w);
      in_data  = w;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_exp(input logic [31:0] w, input string tag);
      push_word(w, tag);
      send(w);
   endtask

   task automatic drain();
      while (q_pix.size() != 0 || out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic pal_write(input logic [7:0] a, input logic [15:0] d);
      pal_we = 1'b1; pal_waddr = a; pal_wdata = d;
      @(negedge clk);
      pal_we = 1'b0;
      pm[a] = d;
   endtask

   // monitor: scoreboard pop and compare
   logic [15:0] held_pix;
   bit          held = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (held && out_valid) check(out_pix == held_pix, "R7 stalled pixel", 32'(out_pix), 32'(held_pix));
            out_ready = !stall_en || (cyc % 3 != 0);
            held = out_valid && !out_ready;
            held_pix = out_pix;
            if (out_valid && out_ready) begin
               if (q_pix.size() == 0) begin
                  check(1'b0, "R1 unexpected pixel", 32'(out_pix), 32'h0);
               end else begin
                  string pt, wt;
                  logic [15:0] ep;
                  logic [23:0] ew;
                  ep = q_pix.pop_front(); ew = q_wide.pop_front();
                  pt = q_ptag.pop_front(); wt = q_wtag.pop_front();
                  check(out_pix == ep, pt, 32'(out_pix), 32'(ep));
                  check(out_wide == ew, wt, 32'(out_wide), 32'(ew));
               end
            end
         end
      end
   end

   bit done = 1'b0;
   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R13 out_valid after reset", 32'(out_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R13 idle after reset", 32'(out_valid), 32'h0);
      check(in_ready == 1'b1, "R13 ready when empty", 32'(in_ready), 32'h1);

      // R2 inactive
      cfg_active = 1'b0;
      in_valid = 1'b1; in_data = 32'hDEAD_BEEF;
      repeat (4) @(negedge clk);
      check(in_ready == 1'b0, "R2 in_ready while inactive", 32'(in_ready), 32'h0);
      check(out_valid == 1'b0, "R2 no output while inactive", 32'(out_valid), 32'h0);
      in_valid = 1'b0;
      cfg_active = 1'b1;
      @(negedge clk);

      // R6 palette load
      for (int i = 0; i < 256; i++) pal_write(8'(i), 16'(i * 16'h9E37) ^ 16'h1234);

      // R5 direct path, split 5:6:5, top placement, fill 0
      cfg_bpp = 3'd4; cfg_split = 2'd1; cfg_widen = 2'd0; cfg_fill = 1'b0;
      send_exp(32'hF800_07E0, "R5");
      send_exp(32'h1234_ABCD, "R5");
      send_exp(32'h001F_FFFF, "R5");
      drain();

      // R4 8 bpp with backpressure, split 6:5:5, low placement, fill 1
      stall_en = 1'b1;
      cfg_bpp = 3'd3; cfg_split = 2'd0; cfg_widen = 2'd1; cfg_fill = 1'b1;
      push_word(32'h03_02_01_FF, "R4");
      send(32'h03_02_01_FF);
      check(in_ready == 1'b0, "R8 busy after accept", 32'(in_ready), 32'h0);
      send_exp(32'h80_7F_C3_00, "R4");
      drain();

      // R3 4 bpp, split 5:5:6, copy mode, stalls
      cfg_bpp = 3'd2; cfg_split = 2'd2; cfg_widen = 2'd2;
      send_exp(32'h7654_3210, "R3");
      send_exp(32'hFEDC_BA98, "R3");
      send_exp(32'hA5A5_F00F, "R3");
      drain();
      stall_en = 1'b0;

      // more widening variants on direct path
      cfg_bpp = 3'd4; cfg_split = 2'd1; cfg_widen = 2'd0; cfg_fill = 1'b1;
      send_exp(32'h5555_AAAA, "R5");
      drain();
      cfg_split = 2'd3; cfg_widen = 2'd2;
      send_exp(32'hC618_39E7, "R5");
      drain();
      cfg_split = 2'd2; cfg_widen = 2'd1; cfg_fill = 1'b0;
      send_exp(32'h8421_7BDE, "R5");
      drain();
      cfg_split = 2'd0; cfg_widen = 2'd3; cfg_fill = 1'b1;
      send_exp(32'hFC00_03FF, "R5");
      drain();

      // R1 unsupported depths
      cfg_bpp = 3'd0;
      @(negedge clk);
      check(mode_err == 1'b1, "R1 1bpp flagged", 32'(mode_err), 32'h1);
      check(in_ready == 1'b1, "R1 ready in error", 32'(in_ready), 32'h1);
      send(32'h1111_2222);
      cfg_bpp = 3'd1;
      @(negedge clk);
      check(mode_err == 1'b1, "R1 2bpp flagged", 32'(mode_err), 32'h1);
      send(32'h3333_4444);
      cfg_bpp = 3'd6;
      @(negedge clk);
      check(mode_err == 1'b1, "R1 unused code flagged", 32'(mode_err), 32'h1);
      repeat (6) @(negedge clk);
      check(out_valid == 1'b0, "R1 no pixels from dropped words", 32'(out_valid), 32'h0);
      cfg_bpp = 3'd4;
      @(negedge clk);
      check(mode_err == 1'b0, "R1 flag clears", 32'(mode_err), 32'h0);
      send_exp(32'h0F0F_F0F0, "R1 first pixel after drop");
      drain();

      // R6 rewrite a palette entry
      pal_write(8'd5, 16'hBEEF);
      cfg_bpp = 3'd2; cfg_widen = 2'd0; cfg_split = 2'd1; cfg_fill = 1'b0;
      send_exp(32'h5555_5555, "R6");
      drain();

      check(q_pix.size() == 0, "R7 all pixels delivered", 32'(q_pix.size()), 32'h0);
      done = 1'b1;
      finish_run();
   end

endmodule